// File: doc/BRIEF.md
# DMA Channel Control and Status Register Block

This block holds the software-visible register state of a single descriptor-driven DMA channel. Its core is a 16-bit channel word. The upper byte carries the run-state flags: run, pause, flush, wake, dead, active and a branch-taken indicator. The lower byte is device-dependent status, and both the host and the attached device can read and change it. Every update is masked, so a writer changes only the bits it selects and leaves the rest as they were.

Three selector registers sit next to the channel word: interrupt, branch and wait. Each holds an 8-bit mask and an 8-bit match value. Each one continuously compares the device byte against its pair and gives the channel sequencer a condition-true signal. The block also keeps the command slot pointer. Software loads that pointer while the channel is stopped, and the sequencer loads it as it walks the descriptor list. Descriptor fetch and data movement are outside this block.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset the channel word, all three selector registers and the command pointer read zero, and the three condition outputs read 1, because a zero mask matches a zero value.
- R2: A host write to address 0 carries a mask in `host_wdata[31:16]` and a value in `host_wdata[15:0]`. Only the bits set in the mask take the value, and they change at the next clock edge. The writable bits are 15 run, 14 pause, 13 flush, 12 wake and the device byte 7..0. For example, mask 0x0003 with value 0 clears bits 1..0 and nothing else.
- R3: Bit 11 (dead) and bit 10 (active) ignore host writes. At each edge they take `seq_dead` and `seq_active` ANDed with the new run bit, so clearing run also clears both.
- R4: Wake (bit 12) and flush (bit 13) return to 0 at the edge where `seq_wake_ack` or `seq_flush_ack` is high. If the host sets the same bit in that cycle, the host write wins.
- R5: Bit 8 (branch taken) becomes 1 when `seq_branch_set` is high. A masked host write of 0 clears it, a host write of 1 has no effect, and a set wins over a clear in the same cycle.
- R6: A device write (`dev_we`) applies `dev_val` to the bits of the device byte selected by `dev_mask`. Where the device and a host write select the same bit in the same cycle, the host value wins. The upper byte is never touched by the device.
- R7: Host writes to address 1 (interrupt), 2 (branch) and 3 (wait) store the mask from `host_wdata[15:8]` and the match value from `host_wdata[7:0]`. They read back on the same addresses as `{16'h0, mask, match}`.
- R8: `int_cond`, `br_cond` and `wait_cond` are 1 exactly when (device byte AND selector mask) equals the selector match value. The device byte used is the registered one.
- R9: A host write to address 4 loads the command pointer from `host_wdata[SLOT_W-1:0]` only while run is 0, and it is ignored while run is 1. `seq_ptr_load` loads `seq_ptr_val` in any state and wins over a host write.
- R10: Reading address 0 returns `{16'h0, channel word}`, with bit 9 always 0. Address 4 returns the zero-extended pointer, and addresses 5 to 7 read 0. Host writes to those addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 3 | Host write address |
| host_wdata | input | 32 | Host write data |
| host_raddr | input | 3 | Host read address |
| host_rdata | output | 32 | Host read data (combinational) |
| dev_we | input | 1 | Device byte write strobe |
| dev_mask | input | 8 | Device write bit mask |
| dev_val | input | 8 | Device write value |
| seq_active | input | 1 | Sequencer active level |
| seq_dead | input | 1 | Sequencer dead level |
| seq_branch_set | input | 1 | Sequencer branch-taken pulse |
| seq_wake_ack | input | 1 | Sequencer wake acknowledge |
| seq_flush_ack | input | 1 | Sequencer flush acknowledge |
| seq_ptr_load | input | 1 | Sequencer pointer load strobe |
| seq_ptr_val | input | SLOT_W | Sequencer pointer value |
| status | output | 16 | Registered channel word |
| cmd_ptr | output | SLOT_W | Registered command slot pointer |
| int_cond | output | 1 | Interrupt condition true |
| br_cond | output | 1 | Branch condition true |
| wait_cond | output | 1 | Wait condition true |

## Verification
Any write, acknowledge or sequencer strobe shows up on `status`, `cmd_ptr` and the read mux one clock edge after it is driven. The condition outputs depend on registered state, so they also follow a device-byte or selector change one edge later. The bench drives all inputs on the falling edge and updates its own model of the next state in the same step. It then samples everything on the following falling edge, so every result is compared exactly one edge after its stimulus. The read port is combinational: the bench moves `host_raddr` within the low half-period and compares after a short settle.

// File: rtl/dma_chreg_pkg.sv
package dma_chreg_pkg;
    localparam int WORD_W = 16;
    localparam int BYTE_W = 8;

    localparam int B_RUN    = 15;
    localparam int B_PAUSE  = 14;
    localparam int B_FLUSH  = 13;
    localparam int B_WAKE   = 12;
    localparam int B_DEAD   = 11;
    localparam int B_ACTIVE = 10;
    localparam int B_BRANCH = 8;

    typedef enum logic [2:0] {
        A_CTL  = 3'd0,
        A_ISEL = 3'd1,
        A_BSEL = 3'd2,
        A_WSEL = 3'd3,
        A_PTR  = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic [BYTE_W-1:0] mask;
        logic [BYTE_W-1:0] match;
    } sel_t;

    typedef struct packed {
        logic              run;
        logic              pause;
        logic              flush;
        logic              wake;
        logic              dead;
        logic              active;
        logic              brch;
        logic [BYTE_W-1:0] dev;
    } ctl_t;
endpackage

// File: rtl/chan_ctl_word.sv
module chan_ctl_word
    import dma_chreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [WORD_W-1:0] host_mask,
    input  logic [WORD_W-1:0] host_val,
    input  logic              dev_we,
    input  logic [BYTE_W-1:0] dev_mask,
    input  logic [BYTE_W-1:0] dev_val,
    input  logic              seq_active,
    input  logic              seq_dead,
    input  logic              seq_branch_set,
    input  logic              seq_wake_ack,
    input  logic              seq_flush_ack,
    output logic [WORD_W-1:0] word
);
    ctl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (dev_we)
            st_d.dev = (st_q.dev & ~dev_mask) | (dev_val & dev_mask);
        if (host_we)
            st_d.dev = (st_d.dev & ~host_mask[BYTE_W-1:0])
                     | (host_val[BYTE_W-1:0] & host_mask[BYTE_W-1:0]);
        if (seq_wake_ack)  st_d.wake  = 1'b0;
        if (seq_flush_ack) st_d.flush = 1'b0;
        if (host_we) begin
            if (host_mask[B_RUN])   st_d.run   = host_val[B_RUN];
            if (host_mask[B_PAUSE]) st_d.pause = host_val[B_PAUSE];
            if (host_mask[B_FLUSH]) st_d.flush = host_val[B_FLUSH];
            if (host_mask[B_WAKE])  st_d.wake  = host_val[B_WAKE];
            if (host_mask[B_BRANCH] && !host_val[B_BRANCH]) st_d.brch = 1'b0;
        end
        if (seq_branch_set) st_d.brch = 1'b1;
        st_d.active = st_d.run & seq_active;
        st_d.dead   = st_d.run & seq_dead;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        word           = '0;
        word[B_RUN]    = st_q.run;
        word[B_PAUSE]  = st_q.pause;
        word[B_FLUSH]  = st_q.flush;
        word[B_WAKE]   = st_q.wake;
        word[B_DEAD]   = st_q.dead;
        word[B_ACTIVE] = st_q.active;
        word[B_BRANCH] = st_q.brch;
        word[BYTE_W-1:0] = st_q.dev;
    end

    // R3: with run low, active and dead must read low
    p_idle_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.run |-> (!st_q.active && !st_q.dead));

    // R4: acknowledge without a host re-set drops wake
    p_wake_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_wake_ack && !(host_we && host_mask[B_WAKE] && host_val[B_WAKE]))
        |=> !st_q.wake);

    // R5: a branch event is always recorded
    p_branch_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        seq_branch_set |=> st_q.brch);

    // R6: device writes alone leave the software run controls untouched
    p_dev_low_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_we && !host_we) |=> ($stable(st_q.run) && $stable(st_q.pause)));
endmodule

// File: rtl/sel_cond.sv
module sel_cond
    import dma_chreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [WORD_W-1:0] wdata,
    input  logic [BYTE_W-1:0] dev_byte,
    output logic [WORD_W-1:0] rd,
    output logic              cond
);
    sel_t sel_d, sel_q;

    always_comb begin
        sel_d = sel_q;
        if (we) sel_d = sel_t'(wdata);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sel_q <= '0;
        else        sel_q <= sel_d;
    end

    assign rd   = sel_q;
    assign cond = ((dev_byte & sel_q.mask) == sel_q.match);

    // R7: selector contents hold without a write
    p_sel_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(sel_q));
endmodule

// File: rtl/cmd_slot_ptr.sv
module cmd_slot_ptr #(
    parameter int SLOT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [SLOT_W-1:0] host_val,
    input  logic              running,
    input  logic              seq_load,
    input  logic [SLOT_W-1:0] seq_val,
    output logic [SLOT_W-1:0] ptr
);
    logic [SLOT_W-1:0] ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (seq_load)                 ptr_d = seq_val;
        else if (host_we && !running) ptr_d = host_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign ptr = ptr_q;

    // R9: host writes cannot move the pointer of a running channel
    p_ptr_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !seq_load) |=> $stable(ptr_q));
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dma_chreg_pkg::*;
#(
    parameter int SLOT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [2:0]        host_addr,
    input  logic [31:0]       host_wdata,
    input  logic [2:0]        host_raddr,
    output logic [31:0]       host_rdata,
    input  logic              dev_we,
    input  logic [7:0]        dev_mask,
    input  logic [7:0]        dev_val,
    input  logic              seq_active,
    input  logic              seq_dead,
    input  logic              seq_branch_set,
    input  logic              seq_wake_ack,
    input  logic              seq_flush_ack,
    input  logic              seq_ptr_load,
    input  logic [SLOT_W-1:0] seq_ptr_val,
    output logic [15:0]       status,
    output logic [SLOT_W-1:0] cmd_ptr,
    output logic              int_cond,
    output logic              br_cond,
    output logic              wait_cond
);
    localparam int NSEL = 3;

    logic [WORD_W-1:0] word;
    logic [WORD_W-1:0] sel_rd [NSEL];
    logic [NSEL-1:0]   conds;

    chan_ctl_word u_ctl (
        .clk            (clk),
        .rst_n          (rst_n),
        .host_we        (host_we && host_addr == A_CTL),
        .host_mask      (host_wdata[31:16]),
        .host_val       (host_wdata[15:0]),
        .dev_we         (dev_we),
        .dev_mask       (dev_mask),
        .dev_val        (dev_val),
        .seq_active     (seq_active),
        .seq_dead       (seq_dead),
        .seq_branch_set (seq_branch_set),
        .seq_wake_ack   (seq_wake_ack),
        .seq_flush_ack  (seq_flush_ack),
        .word           (word)
    );

    for (genvar i = 0; i < NSEL; i++) begin : g_sel
        sel_cond u_sel (
            .clk      (clk),
            .rst_n    (rst_n),
            .we       (host_we && host_addr == 3'(i + 1)),
            .wdata    (host_wdata[WORD_W-1:0]),
            .dev_byte (word[BYTE_W-1:0]),
            .rd       (sel_rd[i]),
            .cond     (conds[i])
        );
    end

    cmd_slot_ptr #(.SLOT_W(SLOT_W)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .host_we  (host_we && host_addr == A_PTR),
        .host_val (host_wdata[SLOT_W-1:0]),
        .running  (word[B_RUN]),
        .seq_load (seq_ptr_load),
        .seq_val  (seq_ptr_val),
        .ptr      (cmd_ptr)
    );

    assign status    = word;
    assign int_cond  = conds[0];
    assign br_cond   = conds[1];
    assign wait_cond = conds[2];

    always_comb begin
        host_rdata = '0;
        case (host_raddr)
            A_CTL:  host_rdata[WORD_W-1:0] = word;
            A_ISEL: host_rdata[WORD_W-1:0] = sel_rd[0];
            A_BSEL: host_rdata[WORD_W-1:0] = sel_rd[1];
            A_WSEL: host_rdata[WORD_W-1:0] = sel_rd[2];
            A_PTR:  host_rdata[SLOT_W-1:0] = cmd_ptr;
            default: host_rdata = '0;
        endcase
    end

    // R10: the unused bit 9 never reads as 1
    p_bit9_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !status[9]);
endmodule

// File: tb/sim_dma_chan_regs.sv
module sim_dma_chan_regs;
    localparam int SLOT_W = 8;

    logic              clk = 0;
    logic              rst_n = 0;
    logic              host_we = 0;
    logic [2:0]        host_addr = 0;
    logic [31:0]       host_wdata = 0;
    logic [2:0]        host_raddr = 0;
    logic [31:0]       host_rdata;
    logic              dev_we = 0;
    logic [7:0]        dev_mask = 0, dev_val = 0;
    logic              seq_active = 0, seq_dead = 0, seq_branch_set = 0;
    logic              seq_wake_ack = 0, seq_flush_ack = 0, seq_ptr_load = 0;
    logic [SLOT_W-1:0] seq_ptr_val = 0;
    logic [15:0]       status;
    logic [SLOT_W-1:0] cmd_ptr;
    logic              int_cond, br_cond, wait_cond;

    int vectors = 0, errors = 0;
    bit done = 0;

    logic [15:0]       e_st;
    logic [15:0]       e_sel [3];
    logic [SLOT_W-1:0] e_ptr;

    always #5 clk = ~clk;

    dma_chan_regs #(.SLOT_W(SLOT_W)) u0 (.*);

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic cond_of(logic [15:0] sel, logic [7:0] dv);
        return ((dv & sel[15:8]) == sel[7:0]);
    endfunction

    function automatic logic [31:0] rd_of(logic [2:0] a);
        case (a)
            3'd0: return {16'h0, e_st};
            3'd1: return {16'h0, e_sel[0]};
            3'd2: return {16'h0, e_sel[1]};
            3'd3: return {16'h0, e_sel[2]};
            3'd4: return {24'h0, e_ptr};
            default: return 32'h0;
        endcase
    endfunction

    // next state from the requirements, evaluated with current inputs
    task automatic model_step();
        logic [15:0] n = e_st;
        logic [15:0] hm = host_wdata[31:16], hv = host_wdata[15:0];
        logic hw = host_we && host_addr == 3'd0;
        if (dev_we) n[7:0] = (n[7:0] & ~dev_mask) | (dev_val & dev_mask);
        if (hw) n[7:0] = (n[7:0] & ~hm[7:0]) | (hv[7:0] & hm[7:0]);
        if (seq_wake_ack)  n[12] = 0;
        if (seq_flush_ack) n[13] = 0;
        if (hw) for (int b = 12; b <= 15; b++) if (hm[b]) n[b] = hv[b];
        if (hw && hm[8] && !hv[8]) n[8] = 0;
        if (seq_branch_set) n[8] = 1;
        n[10] = n[15] & seq_active;
        n[11] = n[15] & seq_dead;
        if (seq_ptr_load) e_ptr = seq_ptr_val;
        else if (host_we && host_addr == 3'd4 && !e_st[15]) e_ptr = host_wdata[SLOT_W-1:0];
        for (int i = 0; i < 3; i++)
            if (host_we && host_addr == 3'(i + 1)) e_sel[i] = host_wdata[15:0];
        e_st = n;
    endtask

    task automatic check_all(string req);
        chk({req, " status"}, {16'h0, status}, {16'h0, e_st});
        chk({req, " ptr"}, {24'h0, cmd_ptr}, {24'h0, e_ptr});
        chk({req, " R8 int"}, {31'h0, int_cond}, {31'h0, cond_of(e_sel[0], e_st[7:0])});
        chk({req, " R8 br"}, {31'h0, br_cond}, {31'h0, cond_of(e_sel[1], e_st[7:0])});
        chk({req, " R8 wait"}, {31'h0, wait_cond}, {31'h0, cond_of(e_sel[2], e_st[7:0])});
        host_raddr = 3'($urandom_range(0, 7));
        #1;
        chk({req, " R10 read"}, host_rdata, rd_of(host_raddr));
    endtask

    // inputs are already set (driven after a negedge); apply one edge
    task automatic cycle(string req);
        model_step();
        @(posedge clk);
        @(negedge clk);
        check_all(req);
    endtask

    task automatic idle();
        host_we = 0; dev_we = 0; seq_branch_set = 0; seq_wake_ack = 0;
        seq_flush_ack = 0; seq_ptr_load = 0;
    endtask

    task automatic hwrite(logic [2:0] a, logic [31:0] d);
        host_we = 1; host_addr = a; host_wdata = d;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog act=running exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        e_st = 0; e_ptr = 0;
        for (int i = 0; i < 3; i++) e_sel[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        chk("R1 status", {16'h0, status}, 32'h0);
        chk("R1 ptr", {24'h0, cmd_ptr}, 32'h0);
        chk("R1 conds", {29'h0, int_cond, br_cond, wait_cond}, 32'h7);

        // R2: set device byte, then mask 0x0003 value 0 clears two low bits
        hwrite(0, 32'h00FF_00A7); cycle("R2 set");
        idle(); hwrite(0, 32'h0003_0000); cycle("R2 clear low two");
        chk("R2 low byte", {24'h0, status[7:0]}, 32'hA4);
        // R2/R3: run set, active/dead not writable
        idle(); seq_active = 1; seq_dead = 1;
        hwrite(0, 32'h8C00_8000); cycle("R3 run set");
        idle(); cycle("R3 follow");
        chk("R3 active dead", {30'h0, status[11:10]}, 32'h3);
        hwrite(0, 32'h0C00_0000); cycle("R3 host ignored");
        chk("R3 still set", {30'h0, status[11:10]}, 32'h3);
        idle(); hwrite(0, 32'h8000_0000); cycle("R3 run clear");
        chk("R3 cleared", {30'h0, status[11:10]}, 32'h0);
        seq_active = 0; seq_dead = 0;
        // R4: wake/flush set then ack; host re-set in ack cycle wins
        idle(); hwrite(0, 32'h3000_3000); cycle("R4 set");
        idle(); seq_wake_ack = 1; seq_flush_ack = 1; cycle("R4 ack");
        chk("R4 cleared", {30'h0, status[13:12]}, 32'h0);
        hwrite(0, 32'h1000_1000); cycle("R4 host wins");
        chk("R4 wake kept", {31'h0, status[12]}, 32'h1);
        // R5: branch set, write 1 no effect, clear, set beats clear
        idle(); seq_branch_set = 1; cycle("R5 set");
        idle(); hwrite(0, 32'h0100_0100); cycle("R5 write one");
        chk("R5 held", {31'h0, status[8]}, 32'h1);
        hwrite(0, 32'h0100_0000); cycle("R5 clear");
        chk("R5 cleared", {31'h0, status[8]}, 32'h0);
        seq_branch_set = 1; cycle("R5 set beats clear");
        chk("R5 set wins", {31'h0, status[8]}, 32'h1);
        // R6: overlap, host wins on shared bits
        idle(); dev_we = 1; dev_mask = 8'hF0; dev_val = 8'hFF;
        hwrite(0, 32'h0030_0000); cycle("R6 overlap");
        chk("R6 merged", {24'h0, status[7:0]}, 32'hC4);
        // R7/R8: selector write and conditions
        idle(); hwrite(1, 32'h0000_C0C0); cycle("R7 isel");
        hwrite(2, 32'h0000_0101); cycle("R7 bsel");
        hwrite(3, 32'h0000_0404); cycle("R7 wsel");
        chk("R8 conds", {29'h0, int_cond, br_cond, wait_cond}, 32'h5);
        // R9: pointer locked while running, sequencer load works
        idle(); hwrite(4, 32'h0000_0033); cycle("R9 stopped write");
        hwrite(0, 32'h8000_8000); cycle("R9 run");
        hwrite(4, 32'h0000_0077); cycle("R9 running write");
        chk("R9 locked", {24'h0, cmd_ptr}, 32'h33);
        idle(); seq_ptr_load = 1; seq_ptr_val = 8'h5A; cycle("R9 seq load");
        // R10: unmapped write has no effect
        idle(); hwrite(5, 32'hFFFF_FFFF); cycle("R10 unmapped");
        idle(); hwrite(0, 32'h8000_0000); cycle("R9 stop");

        // random phase
        for (int k = 0; k < 3000; k++) begin
            idle();
            if ($urandom_range(0, 9) < 4) begin
                logic [2:0] a = 3'($urandom_range(0, 5));
                logic [31:0] d = $urandom;
                if (a >= 1 && a <= 3 && $urandom_range(0, 1)) d[7:0] = d[7:0] & d[15:8];
                hwrite(a, d);
            end
            dev_we = ($urandom_range(0, 2) == 0);
            dev_mask = 8'($urandom); dev_val = 8'($urandom);
            seq_active = 1'($urandom); seq_dead = ($urandom_range(0, 7) == 0);
            seq_branch_set = ($urandom_range(0, 7) == 0);
            seq_wake_ack = ($urandom_range(0, 3) == 0);
            seq_flush_ack = ($urandom_range(0, 3) == 0);
            seq_ptr_load = ($urandom_range(0, 7) == 0);
            seq_ptr_val = SLOT_W'($urandom);
            cycle("R2 R6 R9 random");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule